// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a register of `W` bits (eight by default) that performs one of four operations on each rising clock edge, chosen by a 2-bit operation code: keep its contents, move every bit one place toward the top bit, move every bit one place toward bit 0, or capture a whole word from a parallel bus. A dedicated serial input fills the vacated end for each shift direction. An active-low reset clears the register at once, without waiting for a clock edge.

The parallel port is meant to sit on one bidirectional bus. Here the bus is split into three signals: the value the block would drive, a drive-enable, and the value seen on the bus. The integrating level joins them into a single tri-state net. The drive-enable is low when either of two active-low enables is high. It is also low whenever the operation code selects a load, so that another agent can place the load word on the bus. The register keeps working while the drivers are off.

Both end bits are always visible on serial outputs that are never tri-stated. Joining the top-end output of one unit to the upward serial input of the next, and the bottom-end output of that next unit back to the downward serial input of the first, chains units into a longer word that shifts in either direction.

Top module: `ushift_bus`

## Requirements
- R1: While `rst_n` is low, every register bit is 0. The clear takes effect as soon as `rst_n` falls, without a clock edge, and no operation code or clock edge changes the register while `rst_n` stays low.
- R2: With `op` = 2'b00 a rising edge leaves the register unchanged.
- R3: With `op` = 2'b01 a rising edge moves bit i into bit i+1 and loads `ser_up` into bit 0.
- R4: With `op` = 2'b10 a rising edge moves bit i+1 into bit i and loads `ser_dn` into bit W-1.
- R5: With `op` = 2'b11 a rising edge copies `bus_in` into the register.
- R6: `bus_oe` is 1 only when `en_a_n` and `en_b_n` are both 0 and `op` is not 2'b11. It responds to these inputs without a clock edge. `bus_out` always carries the register contents.
- R7: `end_lo` always equals register bit 0 and `end_hi` always equals register bit W-1, whatever the enables are.
- R8: Hold, both shifts, load and reset act on the register in the same way whether `bus_oe` is 1 or 0.
- R9: After `rst_n` rises, the register reads all zeros until the first rising edge that performs a shift or a load.
- R10: Two units, with the first unit's `end_hi` feeding the second unit's `ser_up` and the second unit's `end_lo` feeding the first unit's `ser_dn`, behave as one register of 2W bits in all four operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register acts on rising edges |
| rst_n | input | 1 | Asynchronous clear, active low |
| op | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| en_a_n | input | 1 | First bus drive enable, active low |
| en_b_n | input | 1 | Second bus drive enable, active low |
| ser_up | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_dn | input | 1 | Serial bit entering bit W-1 on a downward shift |
| bus_in | input | W | Value present on the shared bus |
| bus_out | output | W | Register contents offered to the bus |
| bus_oe | output | 1 | Bus driver enable, active high |
| end_lo | output | 1 | Register bit 0, always driven |
| end_hi | output | 1 | Register bit W-1, always driven |

## Verification
A wrong bit in the register shows on `bus_out` right away, because the port has no buffering. For bit 0 or bit W-1 it also shows on the serial outputs right away. Shifts expose a wrong bit within at most 2W edges in a chained pair, since it moves out through a serial output. A wrong enable decode shows on `bus_oe` in the same cycle as the input change, without any clock. A reset that ignored its asynchronous nature would show as nonzero outputs between the fall of `rst_n` and the next edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

    // Per-bit source select; all zero means keep the current value.
    typedef struct packed {
        logic from_below;
        logic from_above;
        logic from_bus;
    } src_sel_t;

    function automatic src_sel_t op_to_sel(input op_e op);
        src_sel_t s;
        s = '0;
        unique case (op)
            OP_UP:   s.from_below = 1'b1;
            OP_DOWN: s.from_above = 1'b1;
            OP_LOAD: s.from_bus   = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic may_drive(input logic a_n, input logic b_n, input op_e op);
        return !a_n && !b_n && (op != OP_LOAD);
    endfunction

endpackage

// File: rtl/ushift_op_decode.sv
module ushift_op_decode
    import ushift_pkg::*;
(
    input  logic [1:0] op,
    output src_sel_t   sel
);
    op_e op_q;

    always_comb begin
        op_q = op_e'(op);
        sel  = op_to_sel(op_q);
    end
endmodule

// File: rtl/ushift_bit_cell.sv
module ushift_bit_cell
    import ushift_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_t sel,
    input  logic     below,
    input  logic     above,
    input  logic     par,
    output logic     q
);
    logic d;

    always_comb begin
        d = q;
        if (sel.from_below)      d = below;
        else if (sel.from_above) d = above;
        else if (sel.from_bus)   d = par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/ushift_drive_ctl.sv
module ushift_drive_ctl
    import ushift_pkg::*;
(
    input  logic       en_a_n,
    input  logic       en_b_n,
    input  logic [1:0] op,
    output logic       bus_oe
);
    always_comb bus_oe = may_drive(en_a_n, en_b_n, op_e'(op));
endmodule

// File: rtl/ushift_bus.sv
module ushift_bus
    import ushift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op,
    input  logic         en_a_n,
    input  logic         en_b_n,
    input  logic         ser_up,
    input  logic         ser_dn,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         end_lo,
    output logic         end_hi
);
    localparam int MSB = W - 1;
    localparam int EXT = W + 2;

    src_sel_t       sel;
    logic [W-1:0]   q;
    logic [EXT-1:0] chain;

    ushift_op_decode u_dec (
        .op  (op),
        .sel (sel)
    );

    ushift_drive_ctl u_drv (
        .en_a_n (en_a_n),
        .en_b_n (en_b_n),
        .op     (op),
        .bus_oe (bus_oe)
    );

    // chain[0] feeds bit 0 from below, chain[EXT-1] feeds bit MSB from above.
    assign chain = {ser_dn, q, ser_up};

    for (genvar i = 0; i < W; i++) begin : g_bit
        ushift_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel),
            .below (chain[i]),
            .above (chain[i+2]),
            .par   (bus_in[i]),
            .q     (q[i])
        );
    end

    assign bus_out = q;
    assign end_lo  = q[0];
    assign end_hi  = q[MSB];
endmodule

// File: rtl/ushift_bus_chk.sv
module ushift_bus_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   op,
    input logic         en_a_n,
    input logic         en_b_n,
    input logic         ser_up,
    input logic         ser_dn,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         end_lo,
    input logic         end_hi
);
    // R1
    clear_while_low_chk: assert property (@(posedge clk) !rst_n |-> bus_out == '0);

    // R2
    keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b00 |=> $stable(bus_out));

    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b01 |=> bus_out == {$past(bus_out[W-2:0]), $past(ser_up)});

    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b10 |=> bus_out == {$past(ser_dn), $past(bus_out[W-1:1])});

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b11 |=> bus_out == $past(bus_in));

    // R6
    load_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b11 |-> !bus_oe);

    // R6
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_n || en_b_n) |-> !bus_oe);

    // R7
    ends_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_lo == bus_out[0] && end_hi == bus_out[W-1]);

    // R9
    release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> bus_out == '0);
endmodule

bind ushift_bus ushift_bus_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .en_a_n  (en_a_n),
    .en_b_n  (en_b_n),
    .ser_up  (ser_up),
    .ser_dn  (ser_dn),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .end_lo  (end_lo),
    .end_hi  (end_hi)
);

// File: tb/sim_ushift_bus.sv
module sim_ushift_bus;
    localparam int W  = 8;
    localparam int W2 = 2 * W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n  = 1'b1;
    logic [1:0]    op     = 2'b00;
    logic          en_a_n = 1'b0;
    logic          en_b_n = 1'b0;
    logic          ser_up = 1'b0;
    logic          ser_dn = 1'b0;
    logic [W2-1:0] ext_val = '0;

    logic [W-1:0] lo_in, lo_out, hi_in, hi_out;
    logic lo_oe, hi_oe, lo_e0, lo_e7, hi_e0, hi_e7;

    // Shared bus: a unit drives when enabled, otherwise the bench drives.
    assign lo_in = lo_oe ? lo_out : ext_val[W-1:0];
    assign hi_in = hi_oe ? hi_out : ext_val[W2-1:W];

    ushift_bus #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .en_a_n(en_a_n), .en_b_n(en_b_n),
        .ser_up(ser_up), .ser_dn(hi_e0), .bus_in(lo_in), .bus_out(lo_out),
        .bus_oe(lo_oe), .end_lo(lo_e0), .end_hi(lo_e7)
    );

    ushift_bus #(.W(W)) u1 (
        .clk(clk), .rst_n(rst_n), .op(op), .en_a_n(en_a_n), .en_b_n(en_b_n),
        .ser_up(lo_e7), .ser_dn(ser_dn), .bus_in(hi_in), .bus_out(hi_out),
        .bus_oe(hi_oe), .end_lo(hi_e0), .end_hi(hi_e7)
    );

    logic [W2-1:0] model = '0;
    logic [15:0]   lf = 16'hACE1;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_oe();
        return !en_a_n && !en_b_n && (op != 2'b11);
    endfunction

    task automatic check_all(input string req);
        chk(req, {16'h0, hi_out, lo_out}, {16'h0, model});
        chk("R7", {28'h0, hi_e7, hi_e0, lo_e7, lo_e0},
            {28'h0, model[W2-1], model[W], model[W-1], model[0]});
        chk("R6", {30'h0, hi_oe, lo_oe}, {30'h0, exp_oe(), exp_oe()});
    endtask

    function automatic logic next_bit();
        logic b;
        b  = lf[0];
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        return b;
    endfunction

    // Update the reference from the current inputs, then take one edge.
    task automatic step();
        if (rst_n) begin
            case (op)
                2'b01: model = {model[W2-2:0], ser_up};
                2'b10: model = {ser_dn, model[W2-1:1]};
                2'b11: model = ext_val;
                default: model = model;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        // R1: cleared while reset is low
        check_all("R1");
        op = 2'b11; ext_val = 16'hFFFF;
        step();
        check_all("R1");
        rst_n = 1'b1; op = 2'b00;
        #1 check_all("R9");
        step();
        check_all("R9");

        // R5 / R10: load sweep over all byte values in the low unit
        for (int v = 0; v < 256; v++) begin
            op = 2'b11;
            ext_val = {8'(v) ^ 8'h5A, 8'(v)};
            step();
            check_all("R5");
        end

        // R2 / R8: hold under every enable combination
        for (int k = 0; k < 4; k++) begin
            en_a_n = k[0]; en_b_n = k[1]; op = 2'b00;
            ext_val = ~model;
            step();
            check_all("R2");
        end

        // R3 / R8 / R10: upward shift across both units
        for (int i = 0; i < 40; i++) begin
            en_a_n = i[2]; en_b_n = i[3]; op = 2'b01;
            ser_up = next_bit();
            step();
            check_all("R3");
        end

        // R4 / R8 / R10: downward shift across both units
        for (int i = 0; i < 40; i++) begin
            en_a_n = i[3]; en_b_n = i[1]; op = 2'b10;
            ser_dn = next_bit();
            step();
            check_all("R4");
        end

        // R6: enable decode without clock edges
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                op = 2'(m); en_a_n = k[0]; en_b_n = k[1];
                #1 chk("R6", {30'h0, hi_oe, lo_oe},
                           {30'h0, exp_oe(), exp_oe()});
            end
        end
        en_a_n = 1'b0; en_b_n = 1'b0;

        // R8: load and shift with drivers disabled
        en_a_n = 1'b1; op = 2'b11; ext_val = 16'h8001;
        step();
        check_all("R8");
        op = 2'b01; ser_up = 1'b1;
        step();
        check_all("R8");
        en_a_n = 1'b0;

        // R1: reset falling mid-cycle clears before the next edge
        op = 2'b11; ext_val = 16'hA5C3;
        step();
        check_all("R5");
        op = 2'b01; ser_up = 1'b1;
        #2 rst_n = 1'b0;
        model = '0;
        #1 check_all("R1");
        step();
        check_all("R1");
        // R9: zero after release until a shift
        rst_n = 1'b1; op = 2'b00;
        #1 check_all("R9");
        step();
        check_all("R9");
        op = 2'b01; ser_up = 1'b1;
        step();
        check_all("R3");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule